// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is an eight-pin general purpose I/O port behind a small memory-mapped register interface. Each pin has a direction bit and a stored output bit. Pins configured as outputs drive their stored value and assert their output enable. Pins configured as inputs are sampled through a two-stage synchroniser, and those synchronised samples are what reads return.

The data register is not accessed at a single address. It is reached through a window in which eight address bits act as a per-pin select mask. A write changes only the selected pins, and a read returns only the selected pins. Software can therefore set or clear one pin with a single store, with no read-modify-write and no lock shared between users of different pins. The direction register sits at its own word address outside the window. All other addresses are inert.

Top module: `gpio_mask_port`

## Requirements
- R1: `pin_oe[n]` is 1 exactly when direction bit n is 1 (output). When direction bit n is 0, `pin_out[n]` is 0.
- R2: After reset, all direction bits and stored output bits are 0 (every pin is an input), and `rd_data` is 0.
- R3: Addresses 0x000 to 0x3FC with `addr[1:0]`=0 form the data window. Its select mask is `addr[9:2]`, so pin n alone is reached at address 4<<n (for example, 0x004 for pin 0 and 0x020 for pin 3).
- R4: A data-window write updates stored bit n to `wr_data[n]` only where mask bit n is 1. Every other stored bit keeps its value.
- R5: A data-window write leaves stored bit n unchanged while pin n is an input. After pin n is switched to output, it drives the bit stored before the switch, so the value must be written again.
- R6: A data-window read returns 0 in every bit position whose mask bit is 0.
- R7: In a masked data read, bit n is the stored output bit if pin n is an output. If pin n is an input, bit n is `pin_in[n]` as sampled at the clock edge two edges before the read edge.
- R8: The direction register is at address 0x400. A write there loads all eight bits from `wr_data`, and a read there returns all eight bits.
- R9: Any other address (0x404 and above, anything in the 0x800 range, or any address with `addr[1:0]` nonzero) reads as 0. A write to such an address changes no state.
- R10: `rd_data` is registered. It takes the new read value at the clock edge where `rd_en` is 1 and holds its value at every edge where `rd_en` is 0.
- R11: A read and a write at the same address on the same edge return the state as it was before that write. A data write uses the direction bits from before any update on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 8 | Write data, one bit per pin |
| rd_en | input | 1 | Read strobe for this cycle |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables, 1 = drive |

## Verification
A read and a write of the data window can land on the same edge at the same address. The read must then see the pin view from before the store, while the store itself takes effect for the next access. The bench provokes this by raising `rd_en` and `wr_en` together on the full-mask address, with input and output pins mixed. It judges the result against a behavioural model that computes the read from its old state before applying the write. A second read on the next cycle confirms that the store did land.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Kind of location an access falls on
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2,
    ACC_VOID = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int ADDR_W   = 12,
  parameter int DIR_WORD = 'h100
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output acc_kind_e         kind,
  output logic [NPINS-1:0]  mask,
  output logic              data_we,
  output logic              dir_we,
  output logic              void_we,
  output logic              data_re,
  output logic              dir_re
);

  localparam int MASK_LO = 2;
  localparam int MASK_HI = NPINS + MASK_LO - 1;
  localparam int WORD_W  = ADDR_W - MASK_LO;

  function automatic acc_kind_e classify(input logic [ADDR_W-1:0] a);
    if (a[MASK_LO-1:0] != '0)
      return ACC_VOID;
    if (a[ADDR_W-1:MASK_HI+1] == '0)
      return ACC_DATA;
    if (a[ADDR_W-1:MASK_LO] == WORD_W'(DIR_WORD))
      return ACC_DIR;
    return ACC_VOID;
  endfunction

  function automatic logic [NPINS-1:0] lane_mask(input logic [ADDR_W-1:0] a);
    return a[MASK_HI:MASK_LO];
  endfunction

  acc_kind_e k;

  always_comb begin
    k = (wr_en || rd_en) ? classify(addr) : ACC_NONE;
  end

  assign kind    = k;
  assign mask    = lane_mask(addr);
  assign data_we = wr_en && (k == ACC_DATA);
  assign dir_we  = wr_en && (k == ACC_DIR);
  assign void_we = wr_en && (k == ACC_VOID);
  assign data_re = rd_en && (k == ACC_DATA);
  assign dir_re  = rd_en && (k == ACC_DIR);

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_sync
);

  logic [STAGES-1:0][NPINS-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++)
        stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic             dir_we,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q
);

  // A pin's stored bit may change only if selected and already an output
  function automatic logic lane_update(input logic we, input logic sel, input logic is_out);
    return we && sel && is_out;
  endfunction

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic dir_bit;
    logic out_bit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dir_bit <= 1'b0;
      else if (dir_we)
        dir_bit <= wr_data[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_bit <= 1'b0;
      else if (lane_update(data_we, mask[i], dir_bit))
        out_bit <= wr_data[i];
    end

    assign dir_q[i] = dir_bit;
    assign out_q[i] = out_bit;
  end

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             data_re,
  input  logic             dir_re,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] rd_data
);

  // Per-pin visible level: driven value for outputs, sampled value for inputs
  function automatic logic [NPINS-1:0] pin_view(
    input logic [NPINS-1:0] d,
    input logic [NPINS-1:0] o,
    input logic [NPINS-1:0] s
  );
    return (d & o) | (~d & s);
  endfunction

  logic [NPINS-1:0] rd_next;
  logic [NPINS-1:0] rd_q;

  always_comb begin
    if (data_re)
      rd_next = mask & pin_view(dir_q, out_q, pin_sync);
    else if (dir_re)
      rd_next = dir_q;
    else
      rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_q <= '0;
    else if (rd_en)
      rd_q <= rd_next;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 12,
  parameter int DIR_WORD    = 'h100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wr_data,
  input  logic              rd_en,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  // Named internal events, also observed by the bound checker
  acc_kind_e        acc_kind;
  logic [NPINS-1:0] acc_mask;
  logic             data_we;
  logic             dir_we;
  logic             void_we;
  logic             data_re;
  logic             dir_re;
  logic             void_re;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] pin_sync;

  gpio_addr_decode #(
    .NPINS   (NPINS),
    .ADDR_W  (ADDR_W),
    .DIR_WORD(DIR_WORD)
  ) u_decode (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .kind   (acc_kind),
    .mask   (acc_mask),
    .data_we(data_we),
    .dir_we (dir_we),
    .void_we(void_we),
    .data_re(data_re),
    .dir_re (dir_re)
  );

  assign void_re = rd_en && (acc_kind == ACC_VOID);

  gpio_in_sync #(
    .NPINS (NPINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .pin_sync(pin_sync)
  );

  gpio_ctrl_regs #(
    .NPINS(NPINS)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_we(data_we),
    .dir_we (dir_we),
    .mask   (acc_mask),
    .wr_data(wr_data),
    .dir_q  (dir_q),
    .out_q  (out_q)
  );

  gpio_read_port #(
    .NPINS(NPINS)
  ) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .data_re (data_re),
    .dir_re  (dir_re),
    .mask    (acc_mask),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .pin_sync(pin_sync),
    .rd_data (rd_data)
  );

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [NPINS-1:0] rd_data,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] mask,
  input logic             data_we,
  input logic             dir_we,
  input logic             void_we,
  input logic             data_re,
  input logic             void_re,
  input logic [NPINS-1:0] out_q
);

  // R1
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(pin_oe));

  // R4
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> ((out_q ^ $past(out_q)) & ~$past(mask)) == '0);

  // R4
  no_stray_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(out_q));

  // R5
  input_pin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> ((out_q ^ $past(out_q)) & ~$past(pin_oe)) == '0);

  // R6
  read_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_re |=> (rd_data & ~$past(mask)) == '0);

  // R9
  void_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    void_re |=> rd_data == '0);

  // R9
  void_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    void_we |=> ($stable(out_q) && $stable(pin_oe)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NPINS(NPINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_en  (rd_en),
  .rd_data(rd_data),
  .pin_oe (pin_oe),
  .mask   (acc_mask),
  .data_we(data_we),
  .dir_we (dir_we),
  .void_we(void_we),
  .data_re(data_re),
  .void_re(void_re),
  .out_q  (out_q)
);

// File: tb/tb_gpio_mask_port.sv
module tb_gpio_mask_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  gpio_mask_port dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .pin_in (pin_in),
    .pin_out(pin_out),
    .pin_oe (pin_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0] m_dir, m_out, m_rd;
  logic [7:0] m_pipe[$];
  logic [7:0] m_seen, m_view, m_msk;
  int         m_kind;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 8'h00;
      m_out = 8'h00;
      m_rd  = 8'h00;
      m_pipe = '{8'h00, 8'h00};
    end else begin
      m_seen = m_pipe[0];
      m_msk  = 8'h00;
      if ((addr % 4) != 0) m_kind = 3;
      else if (addr < 12'h400) begin m_kind = 1; m_msk = 8'((addr >> 2) & 12'hFF); end
      else if (addr == 12'h400) m_kind = 2;
      else m_kind = 3;
      for (int b = 0; b < 8; b++) m_view[b] = m_dir[b] ? m_out[b] : m_seen[b];
      if (rd_en) m_rd = (m_kind == 1) ? (m_view & m_msk) : (m_kind == 2) ? m_dir : 8'h00;
      if (wr_en) begin
        if (m_kind == 1) begin
          for (int b = 0; b < 8; b++) if (m_msk[b] && m_dir[b]) m_out[b] = wr_data[b];
        end else if (m_kind == 2) begin
          m_dir = wr_data;
        end
      end
      m_pipe.push_back(pin_in);
      void'(m_pipe.pop_front());
    end
  end

  // Compare on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 pin_oe vs model", pin_oe, m_dir);
      check("R5 pin_out vs model", pin_out, m_out & m_dir);
      check("R7 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic cyc(input logic [11:0] a, input logic we, input logic [7:0] wd, input logic re);
    addr = a; wr_en = we; wr_data = wd; rd_en = re;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] wd);
    cyc(a, 1'b1, wd, 1'b0);
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(a, 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    check("R2 pin_oe after reset", pin_oe, 8'h00);
    check("R2 pin_out after reset", pin_out, 8'h00);
    check("R2 rd_data after reset", rd_data, 8'h00);
    rd(12'h400);
    check("R2 direction reads 0", rd_data, 8'h00);

    // R5: writes to input pins are dropped
    wr(12'h3FC, 8'hFF);
    wr(12'h400, 8'h0F);
    rd(12'h400);
    check("R8 direction readback", rd_data, 8'h0F);
    check("R1 pin_oe follows direction", pin_oe, 8'h0F);
    check("R5 earlier input write not stored", pin_out, 8'h00);

    wr(12'h3FC, 8'hA5);
    check("R4 full-mask write on outputs", pin_out, 8'h05);
    wr(12'h004, 8'h00);
    check("R3 pin0 alone cleared", pin_out, 8'h04);
    wr(12'h020, 8'hFF);
    check("R3 pin3 alone set, others kept", pin_out, 8'h0C);

    // R7: input view through synchroniser
    pin_in = 8'h30;
    repeat (2) @(negedge clk);
    rd(12'h3FC);
    check("R7 mixed view", rd_data, 8'h3C);
    rd(12'h044);
    check("R6 masked read zeroes others", rd_data, 8'h10);

    // R7: two-edge latency
    pin_in = 8'hF0;
    rd(12'h3FC);
    check("R7 latency edge 0 old", rd_data, 8'h3C);
    rd(12'h3FC);
    check("R7 latency edge 1 old", rd_data, 8'h3C);
    rd(12'h3FC);
    check("R7 latency edge 2 new", rd_data, 8'hFC);

    // R10: hold without read
    repeat (3) @(negedge clk);
    check("R10 rd_data held", rd_data, 8'hFC);

    // R9: unmapped locations
    wr(12'h404, 8'hFF);
    wr(12'h800, 8'hFF);
    wr(12'h3FE, 8'h00);
    check("R9 writes ignored pin_out", pin_out, 8'h0C);
    check("R9 writes ignored pin_oe", pin_oe, 8'h0F);
    rd(12'h404);
    check("R9 unmapped read", rd_data, 8'h00);
    rd(12'h3FD);
    check("R9 misaligned read", rd_data, 8'h00);
    rd(12'h400);
    check("R9 direction untouched", rd_data, 8'h0F);

    // R11: read and write on the same edge
    cyc(12'h3FC, 1'b1, 8'h00, 1'b1);
    check("R11 read sees pre-write state", rd_data, 8'hFC);
    rd(12'h3FC);
    check("R11 write landed", rd_data, 8'hF0);

    // R5: switching to output drives the old stored value
    wr(12'h400, 8'hFF);
    check("R5 stale value after switch", pin_out, 8'h00);
    wr(12'h3FC, 8'h5A);
    check("R5 rewrite after switch", pin_out, 8'h5A);
    rd(12'h3FC);
    check("R7 output view", rd_data, 8'h5A);

    // R2: reset in mid-run
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R2 pin_oe after mid reset", pin_oe, 8'h00);
    check("R2 rd_data after mid reset", rd_data, 8'h00);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R2 pin_out after mid reset", pin_out, 8'h00);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule